// File: doc/BRIEF.md
# Serial Flash Clock Generator

This block turns a single parent clock into two clocks for a serial-flash interface. One is the main interface clock and the other is a companion clock at half its rate. Both are set by one small control register that software writes through a simple write port and can read back at any time.

The main clock passes through two stages. A source stage divides the parent by one of two fixed ratios, 5 or 6. A second stage then applies an even ratio from 2 to 8. The half-rate clock is the main clock divided by two after gating. Each output has a gate bit, and the gate disables its clock when set. A register code that does not select a valid ratio is dropped for that field alone, so the previous ratio stays in use. New ratios and gate states take effect only where a main clock cycle ends. Both outputs are full-cycle, 50 % duty waveforms and never carry a shortened pulse.

Top module: `sfclk_gen`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x311 (both gates set, source code 2, main code 1) and both clock outputs are low.
- R2: The source field is `cfg_wdata[4:3]`. Code 2 selects a pre-divide of 5 and code 3 a pre-divide of 6. A write carrying code 0 or 1 leaves this field, and the pre-divide, unchanged.
- R3: The main-ratio field is `cfg_wdata[2:0]`. Codes 1, 3, 5 and 7 select division by 2, 4, 6 and 8. A write carrying an even code leaves this field, and the ratio, unchanged, and the two fields are judged independently.
- R4: With the main gate clear, `flash_clk_o` has a period of P*N parent cycles, where P is the pre-divide and N the main ratio, and it is high for exactly half of that period.
- R5: With both gates clear, `flash_half_clk_o` has a period of 2*P*N parent cycles, is high for P*N of them, and rises only on a cycle where `flash_clk_o` also rises.
- R6: Bit 8 set holds both outputs low, because the half-rate clock is derived from the gated main clock. Bit 9 set holds only `flash_half_clk_o` low. A cleared bit enables its clock.
- R7: Changes to ratios and gates take effect only at the end of a main clock cycle. A high pulse of `flash_clk_o` is never shorter than 5 parent cycles, and a high pulse of `flash_half_clk_o` is never shorter than 10.
- R8: Every write stores both gate bits exactly as given. `cfg_rdata` returns the stored gates in bits 9:8, the source field in bits 4:3 and the main field in bits 2:0, and reads 0 in all other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | Write strobe for the control register |
| cfg_wdata | input | 10 | Write data: gates 9:8, source 4:3, main ratio 2:0 |
| cfg_rdata | output | 10 | Current control register contents |
| flash_clk_o | output | 1 | Gated main interface clock |
| flash_half_clk_o | output | 1 | Gated half-rate companion clock |

## Verification
The assertions check several properties on every cycle. The stored fields always hold legal codes. A write with a reserved code leaves its field unchanged, and gate bits are stored as written. Neither output rises while its gate, as sampled at that boundary, is set. The half-rate clock rises only with the main clock, and no high pulse is shorter than the smallest legal half period. The exact periods and duty cycles for each pre-divide and ratio pair can only be shown by the bench scenarios. The same holds for a change made in mid-cycle, which must first complete the old cycle, and for the long-run silence of a gated output.

// File: rtl/sfclk_pkg.sv
package sfclk_pkg;

  localparam int CTRL_W        = 10;
  localparam int DIV_W         = 3;
  localparam int SRC_W         = 2;
  localparam int DIV_LSB       = 0;
  localparam int SRC_LSB       = 3;
  localparam int GATE_MAIN_BIT = 8;
  localparam int GATE_HALF_BIT = 9;

  typedef struct packed {
    logic             gate_half;
    logic             gate_main;
    logic [SRC_W-1:0] src;
    logic [DIV_W-1:0] div;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{gate_half: 1'b1, gate_main: 1'b1,
                                 src: 2'd2, div: 3'd1};

  // Source codes 2 and 3 are the legal ones.
  function automatic logic src_legal(input logic [SRC_W-1:0] code);
    return code[SRC_W-1];
  endfunction

  // Main-ratio codes must be odd; ratio = code + 1.
  function automatic logic div_legal(input logic [DIV_W-1:0] code);
    return code[0];
  endfunction

  function automatic ctrl_t ctrl_unpack(input logic [CTRL_W-1:0] v);
    ctrl_t c;
    c.gate_half = v[GATE_HALF_BIT];
    c.gate_main = v[GATE_MAIN_BIT];
    c.src       = v[SRC_LSB +: SRC_W];
    c.div       = v[DIV_LSB +: DIV_W];
    return c;
  endfunction

  function automatic logic [CTRL_W-1:0] ctrl_pack(input ctrl_t c);
    logic [CTRL_W-1:0] v;
    v                    = '0;
    v[GATE_HALF_BIT]     = c.gate_half;
    v[GATE_MAIN_BIT]     = c.gate_main;
    v[SRC_LSB +: SRC_W]  = c.src;
    v[DIV_LSB +: DIV_W]  = c.div;
    return v;
  endfunction

endpackage

// File: rtl/sfclk_rst_sync.sv
module sfclk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/sfclk_ctrl_reg.sv
module sfclk_ctrl_reg
  import sfclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wdata,
  output ctrl_t             ctrl_q
);

  ctrl_t req;
  ctrl_t ctrl_d;

  always_comb begin
    req    = ctrl_unpack(wdata);
    ctrl_d = ctrl_q;
    ctrl_d.gate_half = req.gate_half;
    ctrl_d.gate_main = req.gate_main;
    // Reserved codes are dropped per field; the old setting stays.
    if (src_legal(req.src)) ctrl_d.src = req.src;
    if (div_legal(req.div)) ctrl_d.div = req.div;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctrl_q <= CTRL_RST;
    else if (wr_en) ctrl_q <= ctrl_d;
  end

endmodule

// File: rtl/sfclk_prediv.sv
module sfclk_prediv #(
  parameter int   PRE_LO = 5,
  parameter int   PRE_HI = 6,
  parameter logic RST_HI = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic sel_hi,
  output logic tick
);

  localparam int PRE_MAX = (PRE_HI > PRE_LO) ? PRE_HI : PRE_LO;
  localparam int CNT_W   = $clog2(PRE_MAX);

  logic [CNT_W-1:0] cnt_q, cnt_d, last;
  logic             hi_q, hi_d;

  always_comb begin
    last  = hi_q ? CNT_W'(PRE_HI - 1) : CNT_W'(PRE_LO - 1);
    tick  = (cnt_q == last);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
    hi_d  = load ? sel_hi : hi_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      hi_q  <= RST_HI;
    end else begin
      cnt_q <= cnt_d;
      hi_q  <= hi_d;
    end
  end

endmodule

// File: rtl/sfclk_maindiv.sv
module sfclk_maindiv #(
  parameter int             DIV_W    = 3,
  parameter logic [DIV_W-1:0] RST_LAST = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [DIV_W-1:0] div_code,
  input  logic             gate,
  output logic             boundary,
  output logic             run_nx,
  output logic             clk_o
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] last_q, last_d;
  logic             en_q, en_d;
  logic             clk_q, clk_d;
  logic [DIV_W:0]   half_len;

  always_comb begin
    boundary = tick && (cnt_q == last_q);
    cnt_d    = cnt_q;
    last_d   = last_q;
    en_d     = en_q;
    if (boundary) begin
      // Only here are ratio and gate taken from the register.
      cnt_d  = '0;
      last_d = div_code;
      en_d   = !gate;
    end else if (tick) begin
      cnt_d  = cnt_q + 1'b1;
    end
    half_len = ({1'b0, last_d} + 1'b1) >> 1;
    clk_d    = en_d && ({1'b0, cnt_d} < half_len);
    run_nx   = en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      last_q <= RST_LAST;
      en_q   <= 1'b0;
      clk_q  <= 1'b0;
    end else if (tick) begin
      cnt_q  <= cnt_d;
      last_q <= last_d;
      en_q   <= en_d;
      clk_q  <= clk_d;
    end
  end

  assign clk_o = clk_q;

endmodule

// File: rtl/sfclk_half.sv
module sfclk_half (
  input  logic clk,
  input  logic rst_n,
  input  logic boundary,
  input  logic run_nx,
  input  logic gate,
  output logic clk_o
);

  logic ph_q, ph_d;
  logic en_q, en_d;
  logic out_q, out_d;

  always_comb begin
    en_d  = !gate;
    ph_d  = run_nx ? !ph_q : ph_q;
    out_d = ph_d && en_d && run_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= 1'b0;
      en_q  <= 1'b0;
      out_q <= 1'b0;
    end else if (boundary) begin
      ph_q  <= ph_d;
      en_q  <= en_d;
      out_q <= out_d;
    end
  end

  assign clk_o = out_q & en_q;

endmodule

// File: rtl/sfclk_gen.sv
module sfclk_gen
  import sfclk_pkg::*;
#(
  parameter int PRE_LO     = 5,
  parameter int PRE_HI     = 6,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CTRL_W-1:0] cfg_wdata,
  output logic [CTRL_W-1:0] cfg_rdata,
  output logic              flash_clk_o,
  output logic              flash_half_clk_o
);

  localparam logic PRE_RST_HI = (CTRL_RST.src == 2'd3);

  logic  srst_n;
  ctrl_t ctrl_q;
  logic  tick;
  logic  boundary;
  logic  run_nx;
  logic  sel_hi;

  sfclk_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  sfclk_ctrl_reg u_reg (
    .clk    (clk),
    .rst_n  (srst_n),
    .wr_en  (cfg_wr),
    .wdata  (cfg_wdata),
    .ctrl_q (ctrl_q)
  );

  assign sel_hi = (ctrl_q.src == 2'd3);

  sfclk_prediv #(
    .PRE_LO (PRE_LO),
    .PRE_HI (PRE_HI),
    .RST_HI (PRE_RST_HI)
  ) u_pre (
    .clk    (clk),
    .rst_n  (srst_n),
    .load   (boundary),
    .sel_hi (sel_hi),
    .tick   (tick)
  );

  sfclk_maindiv #(
    .DIV_W    (DIV_W),
    .RST_LAST (CTRL_RST.div)
  ) u_main (
    .clk      (clk),
    .rst_n    (srst_n),
    .tick     (tick),
    .div_code (ctrl_q.div),
    .gate     (ctrl_q.gate_main),
    .boundary (boundary),
    .run_nx   (run_nx),
    .clk_o    (flash_clk_o)
  );

  sfclk_half u_half (
    .clk      (clk),
    .rst_n    (srst_n),
    .boundary (boundary),
    .run_nx   (run_nx),
    .gate     (ctrl_q.gate_half),
    .clk_o    (flash_half_clk_o)
  );

  assign cfg_rdata = ctrl_pack(ctrl_q);

endmodule

// File: rtl/sfclk_gen_chk.sv
module sfclk_gen_chk
  import sfclk_pkg::*;
#(
  parameter int PRE_LO = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic [CTRL_W-1:0] cfg_wdata,
  input logic [CTRL_W-1:0] cfg_rdata,
  input logic              flash_clk_o,
  input logic              flash_half_clk_o
);

  localparam logic [7:0] MIN_HI   = 8'(PRE_LO);
  localparam logic [7:0] MIN_HALF = 8'(2 * PRE_LO);

  ctrl_t wq, rd;
  always_comb begin
    wq = ctrl_unpack(cfg_wdata);
    rd = ctrl_unpack(cfg_rdata);
  end

  logic [7:0] m_run, h_run;
  logic       m_prev, h_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run  <= '0;
      h_run  <= '0;
      m_prev <= 1'b0;
      h_prev <= 1'b0;
    end else begin
      m_prev <= flash_clk_o;
      h_prev <= flash_half_clk_o;
      if (flash_clk_o != m_prev) m_run <= 8'd1;
      else if (m_run != 8'hFF)   m_run <= m_run + 8'd1;
      if (flash_half_clk_o != h_prev) h_run <= 8'd1;
      else if (h_run != 8'hFF)        h_run <= h_run + 8'd1;
    end
  end

  // R2
  a_r2_src_legal: assert property (@(posedge clk) disable iff (!rst_n)
    src_legal(rd.src));
  a_r2_src_reserved_kept: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && !src_legal(wq.src) |=> rd.src == $past(rd.src));
  // R3
  a_r3_div_legal: assert property (@(posedge clk) disable iff (!rst_n)
    div_legal(rd.div));
  a_r3_div_reserved_kept: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && !div_legal(wq.div) |=> rd.div == $past(rd.div));
  // R8
  a_r8_gate_write: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> rd.gate_main == $past(wq.gate_main) && rd.gate_half == $past(wq.gate_half));
  // R5
  a_r5_half_with_main: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flash_half_clk_o) |-> $rose(flash_clk_o));
  // R6
  a_r6_gate_main: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flash_clk_o) |-> !$past(rd.gate_main));
  a_r6_gate_half: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flash_half_clk_o) |-> !$past(rd.gate_half));
  // R7
  a_r7_min_high_main: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flash_clk_o) |-> m_run >= MIN_HI);
  a_r7_min_high_half: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flash_half_clk_o) |-> h_run >= MIN_HALF);

endmodule

bind sfclk_gen sfclk_gen_chk #(.PRE_LO(PRE_LO)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .cfg_wr           (cfg_wr),
  .cfg_wdata        (cfg_wdata),
  .cfg_rdata        (cfg_rdata),
  .flash_clk_o      (flash_clk_o),
  .flash_half_clk_o (flash_half_clk_o)
);

// File: tb/tb_sfclk_gen.sv
`timescale 1ns/1ps
module tb_sfclk_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [9:0] cfg_wdata = '0;
  logic [9:0] cfg_rdata;
  logic       flash_clk_o;
  logic       flash_half_clk_o;

  always #4 clk = ~clk;   // 125 MHz

  sfclk_gen dut (
    .clk              (clk),
    .rst_n            (rst_n),
    .cfg_wr           (cfg_wr),
    .cfg_wdata        (cfg_wdata),
    .cfg_rdata        (cfg_rdata),
    .flash_clk_o      (flash_clk_o),
    .flash_half_clk_o (flash_half_clk_o)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  task automatic check_eq(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Run-length monitors sampled on the falling edge.
  int  m_len [0:1023];
  bit  m_lvl [0:1023];
  int  m_idx = 0, m_run = 0;
  logic m_prev = 1'b0;
  int  h_len [0:1023];
  bit  h_lvl [0:1023];
  int  h_idx = 0, h_run = 0;
  logic h_prev = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (flash_clk_o === m_prev) m_run++;
      else begin
        m_len[m_idx % 1024] = m_run; m_lvl[m_idx % 1024] = m_prev;
        m_idx++; m_run = 1; m_prev = flash_clk_o;
      end
      if (flash_half_clk_o === h_prev) h_run++;
      else begin
        h_len[h_idx % 1024] = h_run; h_lvl[h_idx % 1024] = h_prev;
        h_idx++; h_run = 1; h_prev = flash_half_clk_o;
      end
    end
  end

  task automatic step(input int n = 1);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic write_reg(input logic [9:0] d);
    step();
    cfg_wr = 1'b1; cfg_wdata = d;
    step();
    cfg_wr = 1'b0; cfg_wdata = '0;
  endtask

  task automatic wait_idx(input int tm, input int th);
    for (int k = 0; k < 3000 && (m_idx < tm || h_idx < th); k++) step();
    check_eq("R4/R5 edges arrive", int'(m_idx >= tm && h_idx >= th), 1);
  endtask

  localparam int NV = 8;
  localparam int VEC_SRC [NV] = '{2, 2, 2, 2, 3, 3, 3, 3};
  localparam int VEC_DIV [NV] = '{1, 3, 5, 7, 1, 3, 5, 7};
  localparam int VEC_PN  [NV] = '{10, 20, 30, 40, 12, 24, 36, 48};

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int bm, bh, pn;
    step(3);
    rst_n = 1'b1;
    step(5);
    // R1: reset state
    check_eq("R1 rdata", int'(cfg_rdata), 'h311);
    check_eq("R1 main low", int'(flash_clk_o), 0);
    check_eq("R1 half low", int'(flash_half_clk_o), 0);
    step(100);
    check_eq("R1 main stays gated", m_idx, 0);
    check_eq("R1 half stays gated", h_idx, 0);

    // R2 R3 R4 R5: walk the vector table
    for (int v = 0; v < NV; v++) begin
      pn = VEC_PN[v];
      write_reg(10'((VEC_SRC[v] << 3) | VEC_DIV[v]));
      check_eq("R8 rdata after legal write", int'(cfg_rdata), (VEC_SRC[v] << 3) | VEC_DIV[v]);
      step(130);
      bm = m_idx; bh = h_idx;
      wait_idx(bm + 3, bh + 3);
      for (int i = 1; i <= 2; i++) begin
        check_eq(m_lvl[(bm + i) % 1024] ? "R4 main high run" : "R4 main low run",
                 m_len[(bm + i) % 1024], pn / 2);
        check_eq(h_lvl[(bh + i) % 1024] ? "R5 half high run" : "R5 half low run",
                 h_len[(bh + i) % 1024], pn);
      end
    end

    // R7: change in mid-cycle finishes the old cycle first
    write_reg(10'h011);
    step(130);
    bm = m_idx;
    for (int k = 0; k < 200; k++) begin
      if (m_idx != bm && m_lvl[(m_idx - 1) % 1024] == 1'b0) break;
      step();
    end
    bm = m_idx;
    write_reg(10'h01F);
    wait_idx(bm + 4, 0);
    check_eq("R7 old high completes", m_len[bm % 1024], 5);
    check_eq("R7 old low completes", m_len[(bm + 1) % 1024], 5);
    check_eq("R7 new high applies", m_len[(bm + 2) % 1024], 24);
    check_eq("R7 new low applies", m_len[(bm + 3) % 1024], 24);

    // R6: main gate stops both clocks
    write_reg(10'h111);
    step(130);
    bm = m_idx; bh = h_idx;
    step(200);
    check_eq("R6 main gated no edges", m_idx - bm, 0);
    check_eq("R6 main gated level", int'(flash_clk_o), 0);
    check_eq("R6 half follows main gate", h_idx - bh, 0);
    check_eq("R6 half level under main gate", int'(flash_half_clk_o), 0);

    // R6: half gate stops only the half clock
    write_reg(10'h211);
    step(130);
    bm = m_idx; bh = h_idx;
    wait_idx(bm + 3, 0);
    check_eq("R6 main runs with half gated", m_len[(bm + 1) % 1024], 5);
    step(200);
    check_eq("R6 half gated no edges", h_idx - bh, 0);
    check_eq("R6 half gated level", int'(flash_half_clk_o), 0);

    // R2 R3: reserved codes keep previous fields
    write_reg(10'h01D);
    check_eq("R3 legal setup", int'(cfg_rdata), 'h01D);
    write_reg(10'h004);
    check_eq("R2 R3 reserved src0 div4 kept", int'(cfg_rdata), 'h01D);
    write_reg(10'h00E);
    check_eq("R2 R3 reserved src1 div6 kept", int'(cfg_rdata), 'h01D);
    step(130);
    bm = m_idx;
    wait_idx(bm + 3, 0);
    check_eq("R2 R3 ratio unchanged", m_len[(bm + 1) % 1024], 18);
    write_reg(10'h016);
    check_eq("R3 fields independent", int'(cfg_rdata), 'h015);

    // R8: unused bits read zero, gates stored as written
    write_reg(10'h3FF);
    check_eq("R8 unused bits zero", int'(cfg_rdata), 'h31F);
    step(130);
    check_eq("R8 gates off main", int'(flash_clk_o), 0);
    check_eq("R8 gates off half", int'(flash_half_clk_o), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule